// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general register storage of a 32-bit processor in which the register a program names depends on the processor mode in force. Each access carries a 4-bit logical index and a 5-bit mode code. A small mapping stage turns that pair into one of thirty physical storage words. Index 15 is not stored: a read of it returns the current instruction address plus a fixed pipeline lead. Two read ports and one write port share the same mapping rules. A separate pair of ports reads and writes the five saved status words, one per exception mode.

The low eight logical registers are common to all modes. The fast-interrupt mode keeps its own copies of indices 8 to 14. The supervisor, abort, undefined and normal-interrupt modes each keep only a private index 13 and 14. User and system modes see exactly the same registers. A per-port user-bank flag lets privileged code reach the user copies of indices 8 to 14, as a block transfer of user context needs. A mode code outside the seven legal ones is flagged on the port, and the access does nothing.

Top module: `mbrf_top`

## Requirements
- R1: After reset every stored general register reads 0 in every legal mode, and every saved status word reads 0.
- R2: Logical indices 0 to 7 address the same physical word in all seven legal modes.
- R3: Fast-interrupt mode (code 10001) has private words for indices 8 to 14. All other legal modes share one copy of indices 8 to 12.
- R4: Supervisor (10011), abort (10111), undefined (11011), normal interrupt (10010) and fast interrupt each have a private index 13 and 14. User (10000) and system (11111) share the user copy.
- R5: User mode and system mode map every index to the same physical word.
- R6: Each of the five exception modes has one saved status word. A saved-status read in user or system mode gives valid 0 and data 0, and a saved-status write in those modes changes nothing.
- R7: A read of index 15 returns pc_i + 8 in any legal mode. A write to index 15 changes no stored register.
- R8: With the port's user flag set, indices 8 to 14 map to the user copies in any mode. Indices 0 to 7 are unaffected.
- R9: A mode code other than the seven above sets the port's illegal flag. An illegal read returns 0, and an illegal write changes nothing.
- R10: A write takes effect at the rising clock edge. Reads are combinational. A read of the word being written in the same cycle returns the old value, and the new value appears after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | Address of the current instruction |
| rd_a_idx | input | 4 | Read port A logical index |
| rd_a_mode | input | 5 | Read port A mode code |
| rd_a_usr | input | 1 | Read port A user-bank flag |
| rd_a_data | output | 32 | Read port A data |
| rd_a_bad | output | 1 | Read port A illegal mode flag |
| rd_b_idx | input | 4 | Read port B logical index |
| rd_b_mode | input | 5 | Read port B mode code |
| rd_b_usr | input | 1 | Read port B user-bank flag |
| rd_b_data | output | 32 | Read port B data |
| rd_b_bad | output | 1 | Read port B illegal mode flag |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write logical index |
| wr_mode | input | 5 | Write mode code |
| wr_usr | input | 1 | Write user-bank flag |
| wr_data | input | 32 | Write data |
| wr_bad | output | 1 | Write port illegal mode flag |
| sr_rd_mode | input | 5 | Saved-status read mode |
| sr_rd_data | output | 32 | Saved-status read data |
| sr_rd_ok | output | 1 | Saved-status read selects a real word |
| sr_wr_en | input | 1 | Saved-status write enable |
| sr_wr_mode | input | 5 | Saved-status write mode |
| sr_wr_data | input | 32 | Saved-status write data |

## Verification
A mapping fault makes two logical names share one physical word, or splits one word in two. The only way to see this at the ports is a write under one name followed by a read under another. So the bench stamps every (mode, index) pair with a distinct value and reads all of them back on both ports. A stale or aliased bank shows up on the first read that follows the write, one clock after the write edge. Because each value is distinct, the value that comes back shows which word the write overwrote. Ignored accesses (index 15, illegal modes, saved status in user or system mode) are each followed by a full readback, so any stray update is visible before the next stimulus.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

    localparam int DATA_W    = 32;
    localparam int IDX_W     = 4;
    localparam int MODE_W    = 5;

    // logical index landmarks
    localparam int FIRST_BANKED = 8;     // first index with a fast-interrupt copy
    localparam int SP_IDX       = 13;    // first index private to every exception mode
    localparam int PC_IDX       = 15;

    // physical layout derived from the landmarks
    localparam int NSHARED   = PC_IDX;                     // user copies of 0..14
    localparam int FIQ_CNT   = PC_IDX - FIRST_BANKED;      // 8..14
    localparam int PAIR_CNT  = PC_IDX - SP_IDX;            // 13..14
    localparam int FIQ_BASE  = NSHARED;
    localparam int SVC_BASE  = FIQ_BASE + FIQ_CNT;
    localparam int ABT_BASE  = SVC_BASE + PAIR_CNT;
    localparam int UND_BASE  = ABT_BASE + PAIR_CNT;
    localparam int IRQ_BASE  = UND_BASE + PAIR_CNT;
    localparam int NGPR      = IRQ_BASE + PAIR_CNT;
    localparam int PHYS_W    = $clog2(NGPR);

    localparam int NSR       = 5;
    localparam int SR_W      = $clog2(NSR);

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    typedef struct packed {
        logic [NGPR-1:0][DATA_W-1:0] gpr;
        logic [NSR-1:0][DATA_W-1:0]  sr;
    } state_t;

    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        case (m)
            MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
            MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

    function automatic logic mode_userlike(input logic [MODE_W-1:0] m);
        return (m == MODE_USR) || (m == MODE_SYS);
    endfunction

    function automatic int pair_base(input logic [MODE_W-1:0] m);
        case (m)
            MODE_SVC: return SVC_BASE;
            MODE_ABT: return ABT_BASE;
            MODE_UND: return UND_BASE;
            MODE_IRQ: return IRQ_BASE;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/mbrf_bank_map.sv
module mbrf_bank_map
    import mbrf_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [MODE_W-1:0] mode,
    input  logic              usr,
    output logic [PHYS_W-1:0] phys,
    output logic              hit,
    output logic              is_pc,
    output logic              bad
);

    localparam logic [IDX_W-1:0] BANK_LO = IDX_W'(FIRST_BANKED);
    localparam logic [IDX_W-1:0] PAIR_LO = IDX_W'(SP_IDX);
    localparam logic [IDX_W-1:0] PC_L    = IDX_W'(PC_IDX);

    always_comb begin
        bad   = !mode_legal(mode);
        is_pc = !bad && (idx == PC_L);
        hit   = !bad && (idx != PC_L);
        if (idx < BANK_LO) begin
            phys = PHYS_W'(idx);
        end else if (usr || mode_userlike(mode)) begin
            phys = PHYS_W'(idx);
        end else if (mode == MODE_FIQ) begin
            phys = PHYS_W'(FIQ_BASE) + PHYS_W'(idx - BANK_LO);
        end else if (idx < PAIR_LO) begin
            phys = PHYS_W'(idx);
        end else begin
            phys = PHYS_W'(pair_base(mode)) + PHYS_W'(idx - PAIR_LO);
        end
    end

    // R9: an illegal mode never selects storage or the pc path
    always_comb begin
        if (bad) begin
            a_r9_bad_no_select: assert (!hit && !is_pc)
                else $error("illegal mode selected a register");
        end
    end

endmodule

// File: rtl/mbrf_sr_map.sv
module mbrf_sr_map
    import mbrf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output logic [SR_W-1:0]   slot,
    output logic              ok
);

    always_comb begin
        ok   = 1'b1;
        slot = '0;
        case (mode)
            MODE_FIQ: slot = SR_W'(0);
            MODE_IRQ: slot = SR_W'(1);
            MODE_SVC: slot = SR_W'(2);
            MODE_ABT: slot = SR_W'(3);
            MODE_UND: slot = SR_W'(4);
            default:  ok   = 1'b0;
        endcase
    end

endmodule

// File: rtl/mbrf_top.sv
module mbrf_top
    import mbrf_pkg::*;
#(
    parameter int PC_AHEAD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pc_i,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [MODE_W-1:0] rd_a_mode,
    input  logic              rd_a_usr,
    output logic [DATA_W-1:0] rd_a_data,
    output logic              rd_a_bad,
    input  logic [IDX_W-1:0]  rd_b_idx,
    input  logic [MODE_W-1:0] rd_b_mode,
    input  logic              rd_b_usr,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              rd_b_bad,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic              wr_usr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_bad,
    input  logic [MODE_W-1:0] sr_rd_mode,
    output logic [DATA_W-1:0] sr_rd_data,
    output logic              sr_rd_ok,
    input  logic              sr_wr_en,
    input  logic [MODE_W-1:0] sr_wr_mode,
    input  logic [DATA_W-1:0] sr_wr_data
);

    localparam int NRD   = 2;
    localparam int NPORT = NRD + 1;     // read ports first, write port last
    localparam int WP    = NRD;

    state_t st_d, st_q;

    logic [NPORT-1:0][IDX_W-1:0]  m_idx;
    logic [NPORT-1:0][MODE_W-1:0] m_mode;
    logic [NPORT-1:0]             m_usr;
    logic [NPORT-1:0][PHYS_W-1:0] m_phys;
    logic [NPORT-1:0]             m_hit;
    logic [NPORT-1:0]             m_pc;
    logic [NPORT-1:0]             m_bad;
    logic [NRD-1:0][DATA_W-1:0]   rdata;

    assign m_idx  = {wr_idx,  rd_b_idx,  rd_a_idx};
    assign m_mode = {wr_mode, rd_b_mode, rd_a_mode};
    assign m_usr  = {wr_usr,  rd_b_usr,  rd_a_usr};

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_map
            mbrf_bank_map u_map (
                .idx   (m_idx[p]),
                .mode  (m_mode[p]),
                .usr   (m_usr[p]),
                .phys  (m_phys[p]),
                .hit   (m_hit[p]),
                .is_pc (m_pc[p]),
                .bad   (m_bad[p])
            );
        end
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            always_comb begin
                if (m_bad[r])
                    rdata[r] = '0;
                else if (m_pc[r])
                    rdata[r] = pc_i + DATA_W'(PC_AHEAD);
                else
                    rdata[r] = st_q.gpr[m_phys[r]];
            end
        end
    endgenerate

    assign rd_a_data = rdata[0];
    assign rd_b_data = rdata[1];
    assign rd_a_bad  = m_bad[0];
    assign rd_b_bad  = m_bad[1];
    assign wr_bad    = m_bad[WP];

    // saved status mapping
    logic [SR_W-1:0] sr_rslot, sr_wslot;
    logic            sr_rvalid, sr_wvalid;

    mbrf_sr_map u_sr_rd (.mode(sr_rd_mode), .slot(sr_rslot), .ok(sr_rvalid));
    mbrf_sr_map u_sr_wr (.mode(sr_wr_mode), .slot(sr_wslot), .ok(sr_wvalid));

    assign sr_rd_ok   = sr_rvalid;
    assign sr_rd_data = sr_rvalid ? st_q.sr[sr_rslot] : '0;

    // next state
    always_comb begin
        st_d = st_q;
        if (wr_en && m_hit[WP])
            st_d.gpr[m_phys[WP]] = wr_data;
        if (sr_wr_en && sr_wvalid)
            st_d.sr[sr_wslot] = sr_wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R9: illegal write leaves storage untouched
    a_r9_bad_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bad) |=> $stable(st_q.gpr));

    // R7: a write to index 15 leaves storage untouched
    a_r7_pc_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(PC_IDX)) |=> $stable(st_q.gpr));

    // R6: saved-status writes in user or system mode are dropped
    a_r6_sr_user_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en && mode_userlike(sr_wr_mode)) |=> $stable(st_q.sr));

    // R6: no valid saved word means zero data
    a_r6_sr_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_rd_ok |-> (sr_rd_data == '0));

    // R2: indices 0..7 agree across any two legal modes
    a_r2_low_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == rd_b_idx && rd_a_idx < IDX_W'(FIRST_BANKED) && !rd_a_bad && !rd_b_bad)
        |-> (rd_a_data == rd_b_data));

    // R5: user and system see the same word
    a_r5_user_system_same: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == rd_b_idx && rd_a_usr == rd_b_usr
         && rd_a_mode == MODE_USR && rd_b_mode == MODE_SYS)
        |-> (rd_a_data == rd_b_data));

    // R10: a completed write is visible through the same name next cycle
    a_r10_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en && !wr_bad && wr_idx != IDX_W'(PC_IDX))
         && rd_a_idx == $past(wr_idx) && rd_a_mode == $past(wr_mode)
         && rd_a_usr == $past(wr_usr))
        |-> (rd_a_data == $past(wr_data)));

endmodule

// File: tb/mbrf_top_tb.sv
module mbrf_top_tb;
    import mbrf_pkg::*;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] pc_i = 32'h0000_1000;
    logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
    logic [4:0]  rd_a_mode = 5'b10000, rd_b_mode = 5'b10000, wr_mode = 5'b10000;
    logic        rd_a_usr = 0, rd_b_usr = 0, wr_usr = 0, wr_en = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_a_data, rd_b_data, sr_rd_data;
    logic        rd_a_bad, rd_b_bad, wr_bad, sr_rd_ok;
    logic [4:0]  sr_rd_mode = 5'b10000, sr_wr_mode = 5'b10000;
    logic        sr_wr_en = 0;
    logic [31:0] sr_wr_data = 0;

    always #5 clk = ~clk;

    mbrf_top u_dut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i),
        .rd_a_idx(rd_a_idx), .rd_a_mode(rd_a_mode), .rd_a_usr(rd_a_usr),
        .rd_a_data(rd_a_data), .rd_a_bad(rd_a_bad),
        .rd_b_idx(rd_b_idx), .rd_b_mode(rd_b_mode), .rd_b_usr(rd_b_usr),
        .rd_b_data(rd_b_data), .rd_b_bad(rd_b_bad),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_mode(wr_mode), .wr_usr(wr_usr),
        .wr_data(wr_data), .wr_bad(wr_bad),
        .sr_rd_mode(sr_rd_mode), .sr_rd_data(sr_rd_data), .sr_rd_ok(sr_rd_ok),
        .sr_wr_en(sr_wr_en), .sr_wr_mode(sr_wr_mode), .sr_wr_data(sr_wr_data)
    );

    logic [4:0] modes [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                              5'b10111, 5'b11011, 5'b11111};

    typedef struct {
        logic [31:0] exp_d;
        logic        exp_f;
        int          port;
        string       tag;
    } item_t;

    item_t sbq[$];
    event  chk_ev;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    logic [31:0] mdl [int];
    logic [31:0] sr_mdl [int];
    int    seq = 0;

    function automatic bit is_legal(input logic [4:0] m);
        foreach (modes[k]) if (modes[k] == m) return 1;
        return 0;
    endfunction

    function automatic bit is_exc(input logic [4:0] m);
        return is_legal(m) && m != 5'b10000 && m != 5'b11111;
    endfunction

    // storage key from the requirements: which logical names share a word
    function automatic int slot(input logic [4:0] m, input logic [3:0] i, input logic u);
        if (i < 8) return int'(i);
        if (u || m == 5'b10000 || m == 5'b11111) return int'(i);
        if (m == 5'b10001) return 100 + int'(i);
        if (i <= 12) return int'(i);
        return 200 + int'(m) * 16 + int'(i);
    endfunction

    function automatic logic [31:0] model_rd(input logic [4:0] m, input logic [3:0] i, input logic u);
        int k;
        if (!is_legal(m)) return 32'h0;
        if (i == 15) return pc_i + 32'd8;
        k = slot(m, i, u);
        return mdl.exists(k) ? mdl[k] : 32'h0;
    endfunction

    function automatic string tag_of(input logic [4:0] m, input logic [3:0] i);
        if (i < 8) return "R2";
        if (m == 5'b10000 || m == 5'b11111) return "R5";
        if (i < 13) return "R3";
        return "R4";
    endfunction

    // monitor: pops expected items and compares with the ports
    always @(chk_ev) begin
        while (sbq.size() > 0) begin
            item_t       it;
            logic [31:0] ad;
            logic        af;
            it = sbq.pop_front();
            case (it.port)
                0:       begin ad = rd_a_data;  af = rd_a_bad; end
                1:       begin ad = rd_b_data;  af = rd_b_bad; end
                default: begin ad = sr_rd_data; af = sr_rd_ok; end
            endcase
            checks++;
            if (ad !== it.exp_d || af !== it.exp_f) begin
                errors++;
                $display("FAIL %s port%0d: got data=%h flag=%b expected data=%h flag=%b",
                         it.tag, it.port, ad, af, it.exp_d, it.exp_f);
            end
        end
    end

    task automatic rd(input int port, input logic [4:0] m, input logic [3:0] i,
                      input logic u, input string tag);
        item_t it;
        if (port == 0) begin rd_a_mode = m; rd_a_idx = i; rd_a_usr = u; end
        else           begin rd_b_mode = m; rd_b_idx = i; rd_b_usr = u; end
        #1;
        it.exp_d = model_rd(m, i, u);
        it.exp_f = !is_legal(m);
        it.port  = port;
        it.tag   = tag;
        sbq.push_back(it);
        ->chk_ev;
        #1;
    endtask

    task automatic sr_rd(input logic [4:0] m, input string tag);
        item_t it;
        sr_rd_mode = m;
        #1;
        it.exp_f = is_exc(m);
        it.exp_d = (is_exc(m) && sr_mdl.exists(int'(m))) ? sr_mdl[int'(m)] : 32'h0;
        it.port  = 2;
        it.tag   = tag;
        sbq.push_back(it);
        ->chk_ev;
        #1;
    endtask

    task automatic wr(input logic [4:0] m, input logic [3:0] i, input logic u, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_mode = m; wr_idx = i; wr_usr = u; wr_data = d;
        @(posedge clk);
        if (is_legal(m) && i != 15) mdl[slot(m, i, u)] = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic sr_wr(input logic [4:0] m, input logic [31:0] d);
        @(negedge clk);
        sr_wr_en = 1; sr_wr_mode = m; sr_wr_data = d;
        @(posedge clk);
        if (is_exc(m)) sr_mdl[int'(m)] = d;
        @(negedge clk);
        sr_wr_en = 0;
    endtask

    task automatic readback_all(input string force_tag);
        foreach (modes[k]) begin
            for (int i = 0; i < 15; i++) begin
                string t;
                t = (force_tag != "") ? force_tag : tag_of(modes[k], 4'(i));
                rd(0, modes[k], 4'(i), 1'b0, t);
                rd(1, modes[k], 4'(14 - i), 1'b0, (force_tag != "") ? force_tag : tag_of(modes[k], 4'(14 - i)));
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running expected finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state of general and saved registers
        readback_all("R1");
        foreach (modes[k]) sr_rd(modes[k], "R1");

        // stamp every (mode, index) with a distinct value, then read all back
        foreach (modes[k]) begin
            for (int i = 0; i < 15; i++) begin
                seq++;
                wr(modes[k], 4'(i), 1'b0, {3'b0, modes[k], 4'(i), 20'(seq)});
            end
        end
        @(negedge clk);
        readback_all("");

        // R8: user-bank flag in privileged modes reaches user copies
        foreach (modes[k]) begin
            for (int i = 0; i < 15; i++) rd(0, modes[k], 4'(i), 1'b1, "R8");
        end
        wr(5'b10001, 4'd10, 1'b1, 32'hC0DE_0810);
        wr(5'b10011, 4'd14, 1'b1, 32'hC0DE_0314);
        @(negedge clk);
        rd(0, 5'b10000, 4'd10, 1'b0, "R8");
        rd(1, 5'b10001, 4'd10, 1'b0, "R8");
        rd(0, 5'b11111, 4'd14, 1'b0, "R8");
        rd(1, 5'b10011, 4'd14, 1'b0, "R8");

        // R7: program counter read path and ignored write
        pc_i = 32'h0000_2340;
        foreach (modes[k]) rd(0, modes[k], 4'd15, 1'b0, "R7");
        pc_i = 32'hFFFF_FFFC;
        rd(1, 5'b10010, 4'd15, 1'b1, "R7");
        wr(5'b10011, 4'd15, 1'b0, 32'hDEAD_0015);
        wr(5'b10001, 4'd15, 1'b0, 32'hDEAD_1015);
        @(negedge clk);
        readback_all("R7");

        // R9: illegal modes flagged, read zero, write ignored
        rd(0, 5'b10100, 4'd3, 1'b0, "R9");
        rd(1, 5'b00000, 4'd13, 1'b0, "R9");
        rd(0, 5'b11110, 4'd15, 1'b0, "R9");
        wr(5'b10100, 4'd3, 1'b0, 32'hBAD0_0003);
        wr(5'b01011, 4'd13, 1'b0, 32'hBAD0_0013);
        @(negedge clk);
        readback_all("R9");

        // R10: same-cycle read sees old value, new value after the edge
        @(negedge clk);
        wr_en = 1; wr_mode = 5'b10011; wr_idx = 4'd13; wr_usr = 0; wr_data = 32'hA5A5_0013;
        rd(0, 5'b10011, 4'd13, 1'b0, "R10");
        @(posedge clk);
        mdl[slot(5'b10011, 4'd13, 1'b0)] = 32'hA5A5_0013;
        #1;
        wr_en = 0;
        rd(0, 5'b10011, 4'd13, 1'b0, "R10");
        rd(1, 5'b10111, 4'd13, 1'b0, "R10");

        // R6: saved status per exception mode, none in user or system
        foreach (modes[k]) sr_wr(modes[k], {16'h5A00, 11'b0, modes[k]});
        @(negedge clk);
        foreach (modes[k]) sr_rd(modes[k], "R6");
        sr_wr(5'b10000, 32'hFFFF_0000);
        sr_wr(5'b11111, 32'hFFFF_1111);
        sr_wr(5'b10100, 32'hFFFF_2222);
        @(negedge clk);
        foreach (modes[k]) sr_rd(modes[k], "R6");

        #5;
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule